// File: doc/BRIEF.md
# Timestamp Lock Threshold Monitor

This block watches how far a local timestamp counter has wandered from a reference network time and reports whether the two time domains are locked. Both times arrive in the same tick units (one tick is 32 ns). On every sample strobe the block subtracts the local time from the reference time and keeps the signed result. It then takes the magnitude of that result and compares it with a programmable 16-bit threshold. A single sample beyond the threshold drops the lock. The lock comes back only after a programmable run of consecutive samples that stay within it.

Every change of lock state, in either direction, gives a one-cycle event pulse and sets a sticky flag, which software clears. A disable input switches off the whole monitor. While it is high the lock is cleared without an event and samples are ignored. The loop that steers the counter rate lies outside this block. The monitor only observes the counter and reports.

Top module: `tlm_lock_monitor`

## Requirements
- R1: After reset `locked_o`, `lock_evt_o` and `evt_sticky_o` are 0, `diff_o` is 0, and the threshold is 0x26C (620 ticks, about 20 us), so a difference of 620 counts as within and 621 counts as exceeding.
- R2: On a clock edge where `smp_i` is 1 and `sync_off_i` is 0, `diff_o` takes the value `ref_time_i - local_time_i` as a 64-bit two's-complement number, visible in the following cycle.
- R3: A sample exceeds the threshold when the magnitude of the difference is strictly greater than the threshold, whatever the sign of the difference. The most negative difference (-2^63) has its magnitude saturated to 2^63-1, so it always exceeds.
- R4: While locked, one exceeding sample clears `locked_o` in the next cycle.
- R5: While unlocked, `locked_o` rises on the sample that completes N consecutive within-threshold samples, where N is `regain_n_i` (a value of 0 acts as 1). An exceeding sample restarts the run.
- R6: A write (`thr_wr_i` = 1) stores `thr_val_i` as the threshold, clamped up to 0x1F when smaller. The largest value, 0xFFFF, is stored as it is. The new value applies to samples from the next cycle on.
- R7: `lock_evt_o` is 1 for exactly one cycle each time `locked_o` changes because of a sample, whether lock is lost or regained.
- R8: `evt_sticky_o` is set with every event and stays set until `sticky_clr_i` is applied. If an event and a clear fall in the same cycle, the event wins.
- R9: While `sync_off_i` is 1, `locked_o` is forced to 0 without an event, the regain run is cleared, and samples leave `diff_o` unchanged.
- R10: Cycles without `smp_i` leave the lock state, the regain run and `diff_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | 1 | Sample strobe: compare the two times this cycle |
| local_time_i | input | 64 | Local counter time in ticks |
| ref_time_i | input | 64 | Reference time in ticks |
| thr_wr_i | input | 1 | Write strobe for the threshold |
| thr_val_i | input | 16 | Threshold value to write, in ticks |
| regain_n_i | input | 8 | Number of consecutive within-threshold samples needed to regain lock |
| sync_off_i | input | 1 | Disables the monitor |
| sticky_clr_i | input | 1 | Clears the sticky event flag |
| locked_o | output | 1 | Lock status |
| lock_evt_o | output | 1 | One-cycle pulse on every lock-state change |
| evt_sticky_o | output | 1 | Sticky record of events |
| diff_o | output | 64 | Last sampled difference, reference minus local, signed |

## Verification
The comparison is driven with differences that sit exactly on the threshold and one tick beyond it, on both signs. This separates a strictly-greater test from greater-or-equal and shows whether a sign error or a missing magnitude step slipped in. The most negative difference shows whether the magnitude is saturated. Threshold writes below the floor, at the floor and at the top value separate clamping from plain storage. Regain runs interrupted by one exceeding sample, and runs with a count of 0, separate the restart and the minimum-count handling from a plain counter. Long stretches of random samples, writes, disables and clears, checked every cycle against a behavioural model, expose event and sticky ordering faults and faults in the disable path.

// File: rtl/tlm_pkg.sv
package tlm_pkg;

   typedef enum logic {
      ST_UNLOCKED = 1'b0,
      ST_LOCKED   = 1'b1
   } lock_state_e;

   localparam int unsigned THR_FLOOR_DEF = 32'h0000_001F;
   localparam int unsigned THR_RESET_DEF = 32'h0000_026C;

endpackage

// File: rtl/tlm_absdiff.sv
module tlm_absdiff #(
   parameter int W        = 64,
   parameter bit SATURATE = 1'b1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] diff_o,
   output logic [W-1:0] mag_o
);
   localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

   logic [W-1:0] neg_w;

   assign diff_o = a_i - b_i;
   assign neg_w  = diff_o[W-1] ? (~diff_o + 1'b1) : diff_o;

   generate
      if (SATURATE) begin : g_sat
         assign mag_o = (diff_o == MOST_NEG) ? MOST_POS : neg_w;
      end else begin : g_wrap
         assign mag_o = neg_w;
      end
   endgenerate

endmodule

// File: rtl/tlm_thr_reg.sv
module tlm_thr_reg #(
   parameter int          THR_W   = 16,
   parameter int unsigned THR_MIN = 31,
   parameter int unsigned THR_RST = 620
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_i,
   input  logic [THR_W-1:0] val_i,
   output logic [THR_W-1:0] thr_o
);
   localparam logic [THR_W-1:0] FLOOR = THR_W'(THR_MIN);
   localparam logic [THR_W-1:0] RSTV  = THR_W'(THR_RST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   thr_o <= RSTV;
      else if (wr_i) thr_o <= (val_i < FLOOR) ? FLOOR : val_i;
   end

   AST_THR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_i |=> $stable(thr_o)); // R6
   AST_THR_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> thr_o >= FLOOR); // R6

endmodule

// File: rtl/tlm_lock_fsm.sv
module tlm_lock_fsm
   import tlm_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             smp_i,
   input  logic             off_i,
   input  logic             exceed_i,
   input  logic             clr_i,
   input  logic [CNT_W-1:0] regain_n_i,
   output logic             locked_o,
   output logic             evt_o,
   output logic             sticky_o
);
   lock_state_e      st_q, st_n;
   logic [CNT_W-1:0] cnt_q, cnt_n, need_w;
   logic [CNT_W:0]   inc_w;
   logic             evt_n, sticky_n;

   assign need_w = (regain_n_i == '0) ? CNT_W'(1) : regain_n_i;
   assign inc_w  = {1'b0, cnt_q} + 1'b1;

   always_comb begin
      st_n  = st_q;
      cnt_n = cnt_q;
      evt_n = 1'b0;
      if (off_i) begin
         st_n  = ST_UNLOCKED;
         cnt_n = '0;
      end else if (smp_i) begin
         unique case (st_q)
            ST_LOCKED: begin
               if (exceed_i) begin
                  st_n  = ST_UNLOCKED;
                  evt_n = 1'b1;
               end
            end
            default: begin
               if (exceed_i) begin
                  cnt_n = '0;
               end else if (inc_w >= {1'b0, need_w}) begin
                  st_n  = ST_LOCKED;
                  cnt_n = '0;
                  evt_n = 1'b1;
               end else begin
                  cnt_n = inc_w[CNT_W-1:0];
               end
            end
         endcase
      end
      sticky_n = evt_n ? 1'b1 : (clr_i ? 1'b0 : sticky_o);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q     <= ST_UNLOCKED;
         cnt_q    <= '0;
         evt_o    <= 1'b0;
         sticky_o <= 1'b0;
      end else begin
         st_q     <= st_n;
         cnt_q    <= cnt_n;
         evt_o    <= evt_n;
         sticky_o <= sticky_n;
      end
   end

   assign locked_o = (st_q == ST_LOCKED);

   AST_LOSS_ONE_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (smp_i && !off_i && exceed_i && locked_o) |=> (!locked_o && evt_o)); // R4
   AST_EVT_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_o |-> (locked_o != $past(locked_o))); // R7
   AST_STICKY_WITH_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_o |-> sticky_o); // R8
   AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      off_i |=> (!locked_o && !evt_o)); // R9
   AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!smp_i && !off_i) |=> ($stable(locked_o) && !evt_o)); // R10

endmodule

// File: rtl/tlm_lock_monitor.sv
module tlm_lock_monitor
   import tlm_pkg::*;
#(
   parameter int          TIME_W   = 64,
   parameter int          THR_W    = 16,
   parameter int          CNT_W    = 8,
   parameter int unsigned THR_MIN  = THR_FLOOR_DEF,
   parameter int unsigned THR_RST  = THR_RESET_DEF,
   parameter bit          SATURATE = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              smp_i,
   input  logic [TIME_W-1:0] local_time_i,
   input  logic [TIME_W-1:0] ref_time_i,
   input  logic              thr_wr_i,
   input  logic [THR_W-1:0]  thr_val_i,
   input  logic [CNT_W-1:0]  regain_n_i,
   input  logic              sync_off_i,
   input  logic              sticky_clr_i,
   output logic              locked_o,
   output logic              lock_evt_o,
   output logic              evt_sticky_o,
   output logic [TIME_W-1:0] diff_o
);
   generate
      if (TIME_W <= THR_W) begin : g_bad_width
         $error("TIME_W must exceed THR_W");
      end
      if (THR_MIN > THR_RST) begin : g_bad_reset
         $error("THR_RST below THR_MIN");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   logic [TIME_W-1:0] diff_w, mag_w;
   logic [THR_W-1:0]  thr_q;
   logic              exceed_w, take_w;

   tlm_absdiff #(.W(TIME_W), .SATURATE(SATURATE)) u_diff (
      .a_i    (ref_time_i),
      .b_i    (local_time_i),
      .diff_o (diff_w),
      .mag_o  (mag_w)
   );

   tlm_thr_reg #(.THR_W(THR_W), .THR_MIN(THR_MIN), .THR_RST(THR_RST)) u_thr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (thr_wr_i),
      .val_i  (thr_val_i),
      .thr_o  (thr_q)
   );

   assign exceed_w = mag_w > TIME_W'(thr_q);
   assign take_w   = smp_i && !sync_off_i;

   tlm_lock_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .smp_i      (smp_i),
      .off_i      (sync_off_i),
      .exceed_i   (exceed_w),
      .clr_i      (sticky_clr_i),
      .regain_n_i (regain_n_i),
      .locked_o   (locked_o),
      .evt_o      (lock_evt_o),
      .sticky_o   (evt_sticky_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     diff_o <= '0;
      else if (take_w) diff_o <= diff_w;
   end

   AST_DIFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !take_w |=> $stable(diff_o)); // R9
   AST_MAG_POSITIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (SATURATE && smp_i) |-> !mag_w[TIME_W-1]); // R3
   AST_WITHIN_KEEPS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_w && locked_o && (mag_w <= TIME_W'(thr_q))) |=> locked_o); // R4

endmodule

// File: tb/sim_tlm_lock_monitor.sv
module sim_tlm_lock_monitor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp = 1'b0, thr_wr = 1'b0, off = 1'b0, clr = 1'b0;
   logic [63:0] loc = 64'd0, refv = 64'd0;
   logic [15:0] thr_val = 16'd0;
   logic [7:0]  regain_n = 8'd1;
   logic        locked, evt, sticky;
   logic [63:0] diff;

   int errors = 0, checks = 0, cycles = 0;

   // behavioural model state
   bit     m_locked = 0, m_evt = 0, m_sticky = 0;
   int     m_cnt = 0, m_thr = 620;
   longint m_diff = 0;

   always #4 clk = ~clk;

   tlm_lock_monitor u0 (
      .clk_i(clk), .rst_ni(rst_n), .smp_i(smp), .local_time_i(loc),
      .ref_time_i(refv), .thr_wr_i(thr_wr), .thr_val_i(thr_val),
      .regain_n_i(regain_n), .sync_off_i(off), .sticky_clr_i(clr),
      .locked_o(locked), .lock_evt_o(evt), .evt_sticky_o(sticky), .diff_o(diff)
   );

   task automatic chk(bit ok, string tag, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_edge();
      bit ev = 0;
      if (off) begin
         m_locked = 0; m_cnt = 0;
      end else if (smp) begin
         longint d = longint'(refv - loc);
         longint mag;
         bit exc;
         int need = (regain_n == 0) ? 1 : int'(regain_n);
         if (d == 64'sh8000_0000_0000_0000) mag = 64'sh7FFF_FFFF_FFFF_FFFF;
         else mag = (d < 0) ? -d : d;
         exc = mag > longint'(m_thr);
         if (m_locked) begin
            if (exc) begin m_locked = 0; ev = 1; end
         end else if (exc) m_cnt = 0;
         else begin
            m_cnt++;
            if (m_cnt >= need) begin m_locked = 1; m_cnt = 0; ev = 1; end
         end
         m_diff = d;
      end
      if (thr_wr) m_thr = (thr_val < 16'h1F) ? 31 : int'(thr_val);
      if (ev) m_sticky = 1; else if (clr) m_sticky = 0;
      m_evt = ev;
   endtask

   task automatic step();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      chk(locked == m_locked, "R5 locked vs model", longint'(locked), longint'(m_locked));
      chk(evt == m_evt, "R7 event vs model", longint'(evt), longint'(m_evt));
      chk(sticky == m_sticky, "R8 sticky vs model", longint'(sticky), longint'(m_sticky));
      chk(diff == m_diff, "R2 diff vs model", longint'(diff), m_diff);
   endtask

   task automatic sample(longint d);
      loc  = loc + 64'd977;
      refv = loc + 64'(d);
      smp  = 1'b1;
      step();
      smp  = 1'b0;
   endtask

   task automatic wr_thr(int v);
      thr_val = 16'(v); thr_wr = 1'b1;
      step();
      thr_wr = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      loc = 64'h0000_1234_0000_0000;
      repeat (3) @(negedge clk);
      chk(locked == 0, "R1 locked at reset", longint'(locked), 0);
      chk(evt == 0, "R1 event at reset", longint'(evt), 0);
      chk(sticky == 0, "R1 sticky at reset", longint'(sticky), 0);
      chk(diff == 0, "R1 diff at reset", longint'(diff), 0);
      rst_n = 1'b1;
      step();

      // R1: default threshold 620; R5: regain after 3
      regain_n = 8'd3;
      sample(620); sample(-620);
      chk(locked == 0, "R5 not locked after 2 of 3", longint'(locked), 0);
      sample(100);
      chk(locked == 1, "R1 R5 locked after 3 at threshold edge", longint'(locked), 1);
      chk(evt == 1, "R7 regain event", longint'(evt), 1);
      step();
      chk(evt == 0, "R7 event one cycle", longint'(evt), 0);
      sample(621);
      chk(locked == 0, "R1 R4 loss at 621", longint'(locked), 0);
      chk(diff == 64'd621, "R2 diff value", longint'(diff), 621);

      // R10: idle cycles change nothing
      loc = loc + 64'd5; refv = loc + 64'd90000;
      repeat (4) step();
      chk(diff == 64'd621, "R10 diff held without strobe", longint'(diff), 621);

      // R5: run restarts on exceed
      sample(1); sample(2); sample(-700); sample(3); sample(4);
      chk(locked == 0, "R5 run restarted", longint'(locked), 0);
      sample(5);
      chk(locked == 1, "R5 locked after fresh run", longint'(locked), 1);

      // R3: negative side and most negative value
      sample(-621);
      chk(locked == 0, "R3 negative exceed", longint'(locked), 0);
      regain_n = 8'd0;
      sample(0);
      chk(locked == 1, "R5 count 0 acts as 1", longint'(locked), 1);
      loc = 64'd0; refv = 64'h8000_0000_0000_0000; smp = 1'b1; step(); smp = 1'b0;
      chk(locked == 0, "R3 most negative exceeds", longint'(locked), 0);
      loc = 64'h0000_1234_0000_0000;

      // R6: clamp and maximum
      wr_thr(5);
      sample(31);
      chk(locked == 1, "R6 clamped floor within", longint'(locked), 1);
      sample(32);
      chk(locked == 0, "R6 clamped floor exceed", longint'(locked), 0);
      wr_thr(16'hFFFF);
      sample(-65535);
      chk(locked == 1, "R6 max within", longint'(locked), 1);
      sample(65536);
      chk(locked == 0, "R6 max exceed", longint'(locked), 0);

      // R8: clear, and set wins over clear
      clr = 1'b1; step(); clr = 1'b0;
      chk(sticky == 0, "R8 sticky cleared", longint'(sticky), 0);
      clr = 1'b1; sample(10); clr = 1'b0;
      chk(sticky == 1, "R8 set wins over clear", longint'(sticky), 1);

      // R9: disable while locked
      off = 1'b1; step();
      chk(locked == 0, "R9 disable clears lock", longint'(locked), 0);
      chk(evt == 0, "R9 no event on disable", longint'(evt), 0);
      sample(7);
      chk(diff == 64'd10, "R9 sample ignored while disabled", longint'(diff), 10);
      off = 1'b0;

      // random mix against the model
      for (int i = 0; i < 3000; i++) begin
         regain_n = 8'($urandom_range(0, 4));
         off  = ($urandom_range(0, 29) == 0);
         clr  = ($urandom_range(0, 9) == 0);
         thr_wr = ($urandom_range(0, 24) == 0);
         thr_val = 16'($urandom_range(0, 900));
         smp  = ($urandom_range(0, 3) != 0);
         loc  = loc + 64'($urandom_range(1, 5000));
         refv = loc + 64'(longint'($urandom_range(0, 1600)) - 800);
         step();
      end
      smp = 1'b0; off = 1'b0; clr = 1'b0; thr_wr = 1'b0;
      step();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule